// File: doc/BRIEF.md
# Configurable All-to-All Dataflow Switch

This block is the central crossbar of a reconfigurable processing element. A fixed set of modules both produce and consume data: the weight store, the activation store, the multiplier array, the adder array, the partial-sum store and the nonlinear unit, plus external I/O ports. Any producer can be routed to any consumer. Each consumer port owns a small source register that holds the index of the producer it reads from. That register steers the consumer's input multiplexer, so one producer can feed one consumer, several consumers, or all of them at once.

The routing registers are written through a simple configuration port. Writes are expected only when the network moves to a new layer, not on every cycle. Every producer and consumer port carries a valid/ready handshake. A producer keeps its word on offer until it is retired. A word is retired only when every consumer currently selecting that producer is ready in the same cycle, so broadcast consumers move in lockstep.

Module indices are fixed, and a consumer and a producer of the same module share one index. The indices are: weight store 0, activation store 1, multiplier 2, adder 3, partial-sum store 4, nonlinear unit 5, and external I/O from 6 upward. With the default eight ports the source field is 4 bits wide. All-ones (15) is the disconnected code. Any value of 8 or above selects no producer.

Top module: `df_switch`

## Requirements
- R1: A consumer whose source register holds a producer index p in 0..NUM_PROD-1 presents producer p's data word on its data output.
- R2: A configuration write with cfg_we high at a rising clock edge and cfg_cons below NUM_CONS loads cfg_src into that consumer's source register. The new route is visible from the following cycle, and every other consumer's source is left unchanged.
- R3: After reset every source register holds the disconnected code (all ones, 15 by default). Every consumer valid and every producer ready is then low, whatever the producers drive.
- R4: A consumer whose source value is NUM_PROD or above (disconnected or out of range) shows valid low and data zero.
- R5: A consumer's valid output equals the valid input of the producer it selects, in the same cycle.
- R6: A producer's ready is high only when at least one consumer selects it and every consumer selecting it asserts ready. A producer selected by no consumer sees ready low.
- R7: Several consumers that select the same producer all show that producer's data and valid at the same time (one-to-many and broadcast).
- R8: A configuration write whose cfg_cons is NUM_CONS or above changes no source register.
- R9: In a cycle that carries both a configuration write and a transfer, the data, valid and ready seen in that cycle follow the routing held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_cons | input | $clog2(NUM_CONS)+1 | Consumer index to be written |
| cfg_src | input | $clog2(NUM_PROD+1) | Producer index to load; values of NUM_PROD and above disconnect |
| prod_data | input | NUM_PROD*DATA_W | Producer data words, producer p in bits [p*DATA_W +: DATA_W] |
| prod_valid | input | NUM_PROD | Producer valid, one bit per producer |
| prod_ready | output | NUM_PROD | Ready returned to each producer |
| cons_data | output | NUM_CONS*DATA_W | Consumer data words, consumer c in bits [c*DATA_W +: DATA_W] |
| cons_valid | output | NUM_CONS | Valid toward each consumer |
| cons_ready | input | NUM_CONS | Ready from each consumer |

## Verification
A routing write and a handshake transfer can land on the same clock edge. The bench provokes this by rerouting a consumer while that consumer is ready and its old producer is valid. Before the edge it judges that data and ready still follow the old producer and that the new producer sees ready low. After the edge it judges that the new producer has taken over. The broadcast join is also probed with mixed ready patterns among consumers sharing one producer, to confirm that a single lagging consumer holds the word back.

// File: rtl/df_switch_pkg.sv
package df_switch_pkg;
    // Fixed module indices shared by producers and consumers
    localparam int unsigned ADDR_WEIGHT  = 0;
    localparam int unsigned ADDR_ACT     = 1;
    localparam int unsigned ADDR_MUL     = 2;
    localparam int unsigned ADDR_ADD     = 3;
    localparam int unsigned ADDR_PSUM    = 4;
    localparam int unsigned ADDR_NONLIN  = 5;
    localparam int unsigned ADDR_IO_BASE = 6;
    localparam int unsigned IO_PORTS     = 2;
    localparam int unsigned PORTS_DEF    = ADDR_IO_BASE + IO_PORTS;
endpackage

// File: rtl/df_route_table.sv
module df_route_table #(
    parameter int NUM_CONS = 8,
    parameter int SRC_W    = 4,
    parameter int CIDX_W   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [CIDX_W-1:0]         cfg_cons,
    input  logic [SRC_W-1:0]          cfg_src,
    output logic [NUM_CONS*SRC_W-1:0] route_flat
);
    typedef struct packed {
        logic [NUM_CONS-1:0][SRC_W-1:0] src;
    } table_t;

    table_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        for (int c = 0; c < NUM_CONS; c++) begin
            if (cfg_we && (cfg_cons == CIDX_W'(c))) begin
                tbl_d.src[c] = cfg_src;
            end
        end
    end

    // Reset value all ones: every consumer starts disconnected
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '1;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign route_flat = tbl_q.src;

    for (genvar c = 0; c < NUM_CONS; c++) begin : g_chk
        AST_CFG_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_cons == CIDX_W'(c)) |=> (tbl_q.src[c] == $past(cfg_src))); // R2
        AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg_we && cfg_cons == CIDX_W'(c)) |=> $stable(tbl_q.src[c])); // R8
    end
endmodule

// File: rtl/df_src_select.sv
module df_src_select #(
    parameter int NUM_PROD = 8,
    parameter int DATA_W   = 16,
    parameter int SRC_W    = 4
) (
    input  logic [SRC_W-1:0]           src,
    input  logic [NUM_PROD*DATA_W-1:0] prod_data,
    input  logic [NUM_PROD-1:0]        prod_valid,
    output logic [DATA_W-1:0]          data,
    output logic                       valid
);
    // Unmatched source codes leave the outputs at zero
    always_comb begin
        data  = '0;
        valid = 1'b0;
        for (int p = 0; p < NUM_PROD; p++) begin
            if (src == SRC_W'(p)) begin
                data  = prod_data[p*DATA_W +: DATA_W];
                valid = prod_valid[p];
            end
        end
    end
endmodule

// File: rtl/df_ready_join.sv
module df_ready_join #(
    parameter int NUM_PROD = 8,
    parameter int NUM_CONS = 8,
    parameter int SRC_W    = 4
) (
    input  logic [NUM_CONS*SRC_W-1:0] route_flat,
    input  logic [NUM_CONS-1:0]       cons_ready,
    output logic [NUM_PROD-1:0]       prod_ready
);
    for (genvar p = 0; p < NUM_PROD; p++) begin : g_prod
        logic taken_any;
        logic takers_ready;

        always_comb begin
            taken_any    = 1'b0;
            takers_ready = 1'b1;
            for (int c = 0; c < NUM_CONS; c++) begin
                if (route_flat[c*SRC_W +: SRC_W] == SRC_W'(p)) begin
                    taken_any    = 1'b1;
                    takers_ready = takers_ready & cons_ready[c];
                end
            end
        end

        assign prod_ready[p] = taken_any & takers_ready;
    end
endmodule

// File: rtl/df_switch.sv
module df_switch
    import df_switch_pkg::*;
#(
    parameter  int NUM_PROD = PORTS_DEF,
    parameter  int NUM_CONS = PORTS_DEF,
    parameter  int DATA_W   = 16,
    localparam int SRC_W    = $clog2(NUM_PROD + 1),
    localparam int CIDX_W   = $clog2(NUM_CONS) + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_we,
    input  logic [CIDX_W-1:0]          cfg_cons,
    input  logic [SRC_W-1:0]           cfg_src,
    input  logic [NUM_PROD*DATA_W-1:0] prod_data,
    input  logic [NUM_PROD-1:0]        prod_valid,
    output logic [NUM_PROD-1:0]        prod_ready,
    output logic [NUM_CONS*DATA_W-1:0] cons_data,
    output logic [NUM_CONS-1:0]        cons_valid,
    input  logic [NUM_CONS-1:0]        cons_ready
);
    logic [NUM_CONS*SRC_W-1:0] route_flat;

    df_route_table #(
        .NUM_CONS (NUM_CONS),
        .SRC_W    (SRC_W),
        .CIDX_W   (CIDX_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_cons   (cfg_cons),
        .cfg_src    (cfg_src),
        .route_flat (route_flat)
    );

    for (genvar c = 0; c < NUM_CONS; c++) begin : g_cons
        logic [SRC_W-1:0] sel;
        assign sel = route_flat[c*SRC_W +: SRC_W];

        df_src_select #(
            .NUM_PROD (NUM_PROD),
            .DATA_W   (DATA_W),
            .SRC_W    (SRC_W)
        ) u_sel (
            .src        (sel),
            .prod_data  (prod_data),
            .prod_valid (prod_valid),
            .data       (cons_data[c*DATA_W +: DATA_W]),
            .valid      (cons_valid[c])
        );

        AST_DISC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            (sel >= SRC_W'(NUM_PROD)) |-> (!cons_valid[c] && cons_data[c*DATA_W +: DATA_W] == '0)); // R4
        AST_DATA_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            cons_valid[c] |-> (cons_data[c*DATA_W +: DATA_W] == prod_data[sel*DATA_W +: DATA_W])); // R1
        AST_LAGGARD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
            (sel < SRC_W'(NUM_PROD) && !cons_ready[c]) |-> !prod_ready[sel]); // R6
    end

    df_ready_join #(
        .NUM_PROD (NUM_PROD),
        .NUM_CONS (NUM_CONS),
        .SRC_W    (SRC_W)
    ) u_join (
        .route_flat (route_flat),
        .cons_ready (cons_ready),
        .prod_ready (prod_ready)
    );

    AST_READY_HAS_TAKER: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_valid == '0 && prod_valid != '0) |-> ((prod_ready & prod_valid) == '0)); // R6
endmodule

// File: tb/df_switch_test.sv
module df_switch_test;
    import df_switch_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NP  = PORTS_DEF;
    localparam int NC  = PORTS_DEF;
    localparam int DW  = 16;
    localparam int SW  = $clog2(NP + 1);
    localparam int CW  = $clog2(NC) + 1;
    localparam logic [SW-1:0] DISC = '1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [CW-1:0]     cfg_cons = '0;
    logic [SW-1:0]     cfg_src = '0;
    logic [NP*DW-1:0]  prod_data = '0;
    logic [NP-1:0]     prod_valid = '0;
    logic [NP-1:0]     prod_ready;
    logic [NC*DW-1:0]  cons_data;
    logic [NC-1:0]     cons_valid;
    logic [NC-1:0]     cons_ready = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    df_switch #(.NUM_PROD(NP), .NUM_CONS(NC), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cons(cfg_cons),
        .cfg_src(cfg_src), .prod_data(prod_data), .prod_valid(prod_valid),
        .prod_ready(prod_ready), .cons_data(cons_data), .cons_valid(cons_valid),
        .cons_ready(cons_ready)
    );

    function automatic logic [DW-1:0] word_of(int p);
        return DW'(16'hA000 + p * 16'h0111);
    endfunction

    function automatic logic [DW-1:0] cdata(int c);
        return cons_data[c*DW +: DW];
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cfg_we = 1'b0; cons_ready = '0; prod_valid = '0;
        for (int p = 0; p < NP; p++) prod_data[p*DW +: DW] = word_of(p);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Returns at a falling edge with the write already applied
    task automatic cfg(int c, int s);
        cfg_we = 1'b1; cfg_cons = CW'(c); cfg_src = SW'(s);
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        prod_valid = '1; cons_ready = '1;
        #1;
        check("R3 cons_valid after reset", 64'(cons_valid), 64'(0));
        check("R3 prod_ready after reset", 64'(prod_ready), 64'(0));
    endtask

    task automatic t_route_each();
        do_reset();
        prod_valid = '1;
        for (int p = 0; p < NP; p++) begin
            cfg(ADDR_ADD, p);
            #1;
            check($sformatf("R1 consumer 3 from producer %0d", p), 64'(cdata(ADDR_ADD)), 64'(word_of(p)));
        end
    endtask

    task automatic t_disconnected();
        do_reset();
        prod_valid = '1;
        cfg(ADDR_MUL, ADDR_PSUM);
        cfg(ADDR_MUL, DISC);
        #1;
        check("R4 disconnected valid", 64'(cons_valid[ADDR_MUL]), 64'(0));
        check("R4 disconnected data", 64'(cdata(ADDR_MUL)), 64'(0));
        cfg(ADDR_MUL, NP);
        #1;
        check("R4 out-of-range code 8 valid", 64'(cons_valid[ADDR_MUL]), 64'(0));
        check("R4 out-of-range code 8 data", 64'(cdata(ADDR_MUL)), 64'(0));
    endtask

    task automatic t_valid_follow();
        do_reset();
        cfg(ADDR_NONLIN, ADDR_ACT);
        prod_valid = '0;
        #1;
        check("R5 valid low follows producer", 64'(cons_valid[ADDR_NONLIN]), 64'(0));
        @(negedge clk);
        prod_valid[ADDR_ACT] = 1'b1;
        #1;
        check("R5 valid high follows producer", 64'(cons_valid[ADDR_NONLIN]), 64'(1));
    endtask

    task automatic t_ready_join();
        do_reset();
        prod_valid = '1;
        cfg(1, ADDR_ADD);
        cfg(4, ADDR_ADD);
        cons_ready = '0;
        cons_ready[1] = 1'b1;
        #1;
        check("R6 one taker lagging", 64'(prod_ready[ADDR_ADD]), 64'(0));
        @(negedge clk);
        cons_ready[4] = 1'b1;
        #1;
        check("R6 all takers ready", 64'(prod_ready[ADDR_ADD]), 64'(1));
        @(negedge clk);
        cons_ready = '1;
        #1;
        check("R6 producer with no taker", 64'(prod_ready[ADDR_IO_BASE]), 64'(0));
    endtask

    task automatic t_broadcast();
        do_reset();
        prod_valid = '0;
        for (int c = 0; c < NC; c++) cfg(c, ADDR_IO_BASE + 1);
        prod_valid[ADDR_IO_BASE + 1] = 1'b1;
        #1;
        check("R7 broadcast valid", 64'(cons_valid), 64'({NC{1'b1}}));
        for (int c = 0; c < NC; c++)
            check($sformatf("R7 broadcast data consumer %0d", c), 64'(cdata(c)), 64'(word_of(ADDR_IO_BASE + 1)));
    endtask

    task automatic t_write_isolation();
        do_reset();
        prod_valid = '1;
        cfg(2, ADDR_ACT);
        #1;
        check("R2 written consumer data", 64'(cdata(2)), 64'(word_of(ADDR_ACT)));
        check("R2 neighbours untouched", 64'(cons_valid), 64'(1 << 2));
    endtask

    task automatic t_bad_index();
        do_reset();
        prod_valid = '1;
        cfg(NC, ADDR_WEIGHT);
        cfg(NC + 3, ADDR_MUL);
        #1;
        check("R8 out-of-range consumer index ignored", 64'(cons_valid), 64'(0));
    endtask

    task automatic t_same_cycle();
        do_reset();
        prod_valid = '1;
        cfg(ADDR_WEIGHT, ADDR_MUL);
        cons_ready[ADDR_WEIGHT] = 1'b1;
        cfg_we = 1'b1; cfg_cons = CW'(ADDR_WEIGHT); cfg_src = SW'(ADDR_NONLIN);
        #1;
        check("R9 old route data during write", 64'(cdata(ADDR_WEIGHT)), 64'(word_of(ADDR_MUL)));
        check("R9 old producer retires", 64'(prod_ready[ADDR_MUL]), 64'(1));
        check("R9 new producer not yet ready", 64'(prod_ready[ADDR_NONLIN]), 64'(0));
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        check("R9 new route data after edge", 64'(cdata(ADDR_WEIGHT)), 64'(word_of(ADDR_NONLIN)));
        check("R9 new producer ready after edge", 64'(prod_ready[ADDR_NONLIN]), 64'(1));
        check("R9 old producer released", 64'(prod_ready[ADDR_MUL]), 64'(0));
    endtask

    initial begin
        t_reset();
        t_route_each();
        t_disconnected();
        t_valid_follow();
        t_ready_join();
        t_broadcast();
        t_write_isolation();
        t_bad_index();
        t_same_cycle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule